// File: doc/BRIEF.md
# Period-List Playback DMA Sequencer

This block drives the memory-read side of an audio playback channel whose buffer is a ring of periods. The ring is not one contiguous region. It is a table in memory, and each 8-byte entry of the table describes one period. The first word of an entry is the start address of that period. The second word holds the length of the period in bytes in its upper half-word. The sequencer reads an entry, then requests the period's samples as consecutive 64-byte bursts, then moves to the next entry. After the last entry it returns to the first.

Software programs a few settings on the ports: the table's base address, the byte offset of the table's final entry (0x38 for eight periods, 0x08 for two), and an optional stop point. A one-cycle start pulse then sets the sequencer running. While it runs, the block emits single-cycle event pulses at the middle and at the end of every period, and at the middle and at the wrap of the whole list. The sample FIFO sits outside the block. It tells the sequencer whether it can take another burst. When it cannot, the sequencer flags an underrun and keeps its place.

Top module: `period_list_dma`

## Requirements
- R1: After reset `running`, `cur_index`, `cur_ptr`, `rd_req`, `underrun` and all four event pulses are 0.
- R2: A `start` pulse, in any state, clears `cur_index`, `cur_ptr` and `underrun` on the next edge. It also sets `running`, and the first request that follows is an entry read at `list_base + cur_index`.
- R3: Every period begins with two entry reads (`rd_data`=0), and no data burst is issued before both responses have arrived. The first read is at `list_base + cur_index` and returns the period base address. The second is at `list_base + cur_index + 4`, and bits [31:16] of its response are the period size in bytes. An entry read stays requested at a stable address until `rd_ready` accepts it.
- R4: Data bursts (`rd_data`=1) request `period_base + cur_ptr`. Each accepted burst adds 64 to `cur_ptr`.
- R5: When an accepted burst brings the pointer to or past the period size, `period_end` pulses for one cycle, `cur_ptr` returns to 0, and `cur_index` advances by 8 bytes. The next entry is then fetched.
- R6: `period_half` pulses for one cycle when an accepted burst moves the pointer from below half the period size to at or above it.
- R7: When the period at entry offset `list_last` ends, `cur_index` returns to 0 and `list_wrap` pulses together with `period_end`.
- R8: `list_half` pulses when the index advances from below (`list_last`+8)/2 to at or above it.
- R9: While a burst is due and `fifo_ready` is 0, no data request is made, `cur_ptr` holds, and the sticky `underrun` flag is set. Once `fifo_ready` returns, the same address is requested.
- R10: With `end_stop`=1, an accepted burst that brings `cur_ptr` to `end_addr` halts the sequencer. `running` drops, no further request is made, `cur_ptr` stays at `end_addr`, `cur_index` is unchanged, and no `period_end` pulse is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Restart from entry 0 and run |
| list_base | input | 32 | Byte address of the period table |
| list_last | input | 6 | Byte offset of the final table entry |
| end_stop | input | 1 | Enable halting at `end_addr` |
| end_addr | input | 16 | Within-period byte pointer at which to halt |
| fifo_ready | input | 1 | Sample FIFO can take one more burst |
| rd_req | output | 1 | Read request valid |
| rd_addr | output | 32 | Read request byte address |
| rd_data | output | 1 | 1 = sample burst, 0 = table entry word |
| rd_ready | input | 1 | Memory accepts the request this cycle |
| rsp_valid | input | 1 | Entry-read response valid |
| rsp_data | input | 32 | Entry-read response word |
| running | output | 1 | Sequencer active |
| cur_index | output | 6 | Byte offset of the current table entry |
| cur_ptr | output | 16 | Byte offset within the current period |
| period_half | output | 1 | Mid-period pulse |
| period_end | output | 1 | End-of-period pulse |
| list_half | output | 1 | Mid-list pulse |
| list_wrap | output | 1 | List wrapped to entry 0 pulse |
| underrun | output | 1 | Sticky flag: a burst was due while the FIFO was full |

## Verification
The hardest situation to reach is the list-level event timing. A wrap or mid-list crossing only shows after several periods of unequal length have each gone through a two-read fetch and a run of bursts. The bench therefore keeps a small memory whose three entries have periods of two, three and one bursts. It walks one vector per expected request while it accumulates pulse counts, so that every period-end, half-period, mid-list and wrap event is pinned to the request that follows it. Underrun, stalled acceptance and the stop point are then forced at chosen requests by dropping `fifo_ready` or `rd_ready`, or by setting `end_addr` to the first burst boundary.

// File: rtl/period_list_dma.sv
module period_list_dma #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int PW = 16,
  parameter int IW = 6,
  parameter int BURST_BYTES = 64,
  parameter int ENTRY_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] list_base,
  input  logic [IW-1:0] list_last,
  input  logic          end_stop,
  input  logic [PW-1:0] end_addr,
  input  logic          fifo_ready,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          rd_data,
  input  logic          rd_ready,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          running,
  output logic [IW-1:0] cur_index,
  output logic [PW-1:0] cur_ptr,
  output logic          period_half,
  output logic          period_end,
  output logic          list_half,
  output logic          list_wrap,
  output logic          underrun
);

  localparam int WORD_BYTES = DW / 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_AREQ, ST_ARSP, ST_ZREQ, ST_ZRSP, ST_BURST
  } state_t;

  state_t        state;
  logic [AW-1:0] per_base;
  logic [PW-1:0] per_size;

  logic [PW:0] ptr_next, half_size;
  logic [IW:0] idx_step, list_mid;
  logic        fire, crossed_half, per_done, hit_stop, at_last, mid_cross;

  assign ptr_next     = {1'b0, cur_ptr} + (PW+1)'(BURST_BYTES);
  assign half_size    = {1'b0, per_size} >> 1;
  assign crossed_half = ({1'b0, cur_ptr} < half_size) && (ptr_next >= half_size);
  assign per_done     = ptr_next >= {1'b0, per_size};
  assign hit_stop     = end_stop && (ptr_next == {1'b0, end_addr});

  assign idx_step  = {1'b0, cur_index} + (IW+1)'(ENTRY_BYTES);
  assign list_mid  = ({1'b0, list_last} + (IW+1)'(ENTRY_BYTES)) >> 1;
  assign at_last   = cur_index >= list_last;
  assign mid_cross = !at_last && ({1'b0, cur_index} < list_mid) && (idx_step >= list_mid);

  assign running = state != ST_IDLE;
  assign rd_data = state == ST_BURST;
  assign rd_req  = (state == ST_AREQ) || (state == ST_ZREQ) || (rd_data && fifo_ready);
  assign fire    = rd_data && fifo_ready && rd_ready;

  always_comb begin
    case (state)
      ST_AREQ: rd_addr = list_base + AW'(cur_index);
      ST_ZREQ: rd_addr = list_base + AW'(cur_index) + AW'(WORD_BYTES);
      default: rd_addr = per_base + AW'(cur_ptr);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      per_base    <= '0;
      per_size    <= '0;
      cur_index   <= '0;
      cur_ptr     <= '0;
      underrun    <= 1'b0;
      period_half <= 1'b0;
      period_end  <= 1'b0;
      list_half   <= 1'b0;
      list_wrap   <= 1'b0;
    end else begin
      period_half <= 1'b0;
      period_end  <= 1'b0;
      list_half   <= 1'b0;
      list_wrap   <= 1'b0;
      if (start) begin
        state     <= ST_AREQ;
        cur_index <= '0;
        cur_ptr   <= '0;
        underrun  <= 1'b0;
      end else begin
        case (state)
          ST_AREQ: if (rd_ready) state <= ST_ARSP;
          ST_ARSP: if (rsp_valid) begin
            per_base <= rsp_data[AW-1:0];
            state    <= ST_ZREQ;
          end
          ST_ZREQ: if (rd_ready) state <= ST_ZRSP;
          ST_ZRSP: if (rsp_valid) begin
            per_size <= rsp_data[DW-1 -: PW];
            state    <= ST_BURST;
          end
          ST_BURST: begin
            if (!fifo_ready) begin
              underrun <= 1'b1;
            end else if (rd_ready) begin
              period_half <= crossed_half;
              if (hit_stop) begin
                cur_ptr <= ptr_next[PW-1:0];
                state   <= ST_IDLE;
              end else if (per_done) begin
                cur_ptr    <= '0;
                period_end <= 1'b1;
                list_wrap  <= at_last;
                list_half  <= mid_cross;
                cur_index  <= at_last ? '0 : idx_step[IW-1:0];
                state      <= ST_AREQ;
              end else begin
                cur_ptr <= ptr_next[PW-1:0];
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> running && cur_index == '0 && cur_ptr == '0 && !underrun);

  assert_entry_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_data && !rd_ready && !start) |=> rd_req && !rd_data && $stable(rd_addr));

  assert_end_resets_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> cur_ptr == '0 && running);

  assert_wrap_to_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    list_wrap |-> cur_index == '0 && period_end);

  assert_underrun_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !fifo_ready && !start) |=> underrun && $stable(cur_ptr) && $stable(cur_index));

  assert_stop_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && hit_stop && !start) |=> !running && !rd_req && !period_end && cur_ptr == $past(end_addr));

endmodule

// File: tb/period_list_dma_bench.sv
`timescale 1ns/1ps
module period_list_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] list_base = 32'h0000_1000;
  logic [5:0]  list_last = 6'h10;
  logic        end_stop = 1'b0;
  logic [15:0] end_addr = 16'h0;
  logic        fifo_ready = 1'b1;
  logic        rd_ready = 1'b1;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = 32'h0;
  logic        rd_req, rd_data, running;
  logic [31:0] rd_addr;
  logic [5:0]  cur_index;
  logic [15:0] cur_ptr;
  logic        period_half, period_end, list_half, list_wrap, underrun;

  int n_checks = 0;
  int n_fail = 0;
  int pf = 0, ph = 0, bh = 0, bf = 0;
  logic        pend = 1'b0;
  logic [31:0] pdata = 32'h0;

  always #5 clk = ~clk;

  period_list_dma u_period_list_dma (
    .clk(clk), .rst_n(rst_n), .start(start), .list_base(list_base), .list_last(list_last),
    .end_stop(end_stop), .end_addr(end_addr), .fifo_ready(fifo_ready),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ready(rd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .running(running),
    .cur_index(cur_index), .cur_ptr(cur_ptr), .period_half(period_half),
    .period_end(period_end), .list_half(list_half), .list_wrap(list_wrap),
    .underrun(underrun));

  // {pad4, kind4, period_end#4, period_half#4, list_half#4, list_wrap#4, index8, addr32}
  localparam int NV = 15;
  localparam logic [63:0] VEC [NV] = '{
    64'h0_0_0_0_0_0_00_00001000,
    64'h0_0_0_0_0_0_00_00001004,
    64'h0_1_0_0_0_0_00_00008000,
    64'h0_1_0_1_0_0_00_00008040,
    64'h0_0_1_1_0_0_08_00001008,
    64'h0_0_1_1_0_0_08_0000100C,
    64'h0_1_1_1_0_0_08_00009000,
    64'h0_1_1_1_0_0_08_00009040,
    64'h0_1_1_2_0_0_08_00009080,
    64'h0_0_2_2_1_0_10_00001010,
    64'h0_0_2_2_1_0_10_00001014,
    64'h0_1_2_2_1_0_10_0000A000,
    64'h0_0_3_3_1_1_00_00001000,
    64'h0_0_3_3_1_1_00_00001004,
    64'h0_1_3_3_1_1_00_00008000
  };

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    case (a)
      32'h1000: return 32'h0000_8000;
      32'h1004: return 32'h0080_0000;
      32'h1008: return 32'h0000_9000;
      32'h100C: return 32'h00C0_1234;
      32'h1010: return 32'h0000_A000;
      32'h1014: return 32'h0040_0000;
      default:  return 32'hDEAD_BEEF;
    endcase
  endfunction

  task automatic tick();
    #1;
    pend  = rd_req && rd_ready && !rd_data;
    pdata = mem_word(rd_addr);
    @(negedge clk);
    rsp_valid = pend;
    rsp_data  = pend ? pdata : 32'h0;
    pf += int'(period_end);
    ph += int'(period_half);
    bh += int'(list_half);
    bf += int'(list_wrap);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_req();
    for (int g = 0; g < 100 && !rd_req; g++) tick();
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: idle after reset
    chk("R1", {54'h0, running, cur_index, cur_ptr[0], rd_req, underrun},
              64'h0);
    chk("R1", {48'h0, cur_ptr}, 64'h0);
    chk("R1", {60'h0, period_half, period_end, list_half, list_wrap}, 64'h0);

    start = 1'b1;
    tick();
    start = 1'b0;
    // R2: running, first entry read at list_base
    chk("R2", {56'h0, running, 1'b0, cur_index}, {56'h0, 2'b10, 6'h0});

    // R3 R4 R5 R6 R7 R8: request order, addresses and event counts
    for (int k = 0; k < NV; k++) begin
      if (k > 0) tick();
      wait_req();
      chk("R3 R4 R5 R6 R7 R8",
          {7'h0, rd_data, 4'(pf), 4'(ph), 4'(bh), 4'(bf), 2'b0, cur_index, rd_addr}, VEC[k]);
    end

    // R9: FIFO not ready when the burst at 0x8000 is due
    fifo_ready = 1'b0;
    tick();
    chk("R9", {62'h0, underrun, rd_req}, {62'h0, 2'b10});
    repeat (3) tick();
    chk("R9", {47'h0, rd_req, cur_ptr}, 64'h0);
    fifo_ready = 1'b1;
    #1;
    chk("R9", {31'h0, rd_req, rd_addr}, {31'h0, 1'b1, 32'h0000_8000});
    tick();
    chk("R4", {48'h0, cur_ptr}, 64'h40);

    // R2 restart with a stalled first entry read (R3 hold) and a stop point (R10)
    end_stop = 1'b1;
    end_addr = 16'h0040;
    rd_ready = 1'b0;
    start = 1'b1;
    tick();
    start = 1'b0;
    chk("R2", {40'h0, running, underrun, cur_index, cur_ptr}, {40'h0, 2'b10, 6'h0, 16'h0});
    chk("R2", {31'h0, rd_req, rd_addr}, {31'h0, 1'b1, 32'h0000_1000});
    tick();
    tick();
    chk("R3", {30'h0, rd_req, rd_data, rd_addr}, {30'h0, 2'b10, 32'h0000_1000});
    rd_ready = 1'b1;
    begin
      int pf0;
      pf0 = pf;
      tick();
      for (int g = 0; g < 100 && running; g++) tick();
      chk("R10", {40'h0, running, rd_req, cur_index, cur_ptr}, {40'h0, 2'b00, 6'h0, 16'h0040});
      chk("R10", 64'(pf - pf0), 64'h0);
      repeat (3) tick();
      chk("R10", {62'h0, running, rd_req}, 64'h0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule